// File: doc/BRIEF.md
# Transmit FIFO Flush Controller

This block is a control and status register slice that empties transmit FIFOs on software request. Software writes a 5-bit FIFO select code together with a flush request bit. The controller holds the request until the data path is quiet: no transfer may be in progress and the bus master must report idle. It then drives a one-cycle clear pulse to the pointers of the selected FIFO, or to every FIFO when the select code is the all-FIFOs code. In the cycle after the pulse the hardware clears the request bit, and software polls that bit to learn that the flush has finished.

The same register word shows a live bus-master idle flag in its top bit, so software can confirm the write side is quiet before it asks for a flush. In host mode the two lowest select codes name the non-periodic FIFO (code 0) and the periodic FIFO (code 1). They drive clear lines 0 and 1, exactly as in device mode.

The sequencing is a three-state machine. `ST_IDLE` accepts register writes. `ST_WAIT` holds a pending request. `ST_CLEAR` is the single cycle in which the clear pulse is driven. The transitions are: IDLE→WAIT on a register write with the request bit set; WAIT→CLEAR in the first cycle that sees `master_idle` high and `xfer_active` low; CLEAR→IDLE unconditionally.

Top module: `txf_flush_ctrl`

## Requirements
- R1: During and after reset the select field and the request bit are 0, `fifo_clr` is all zero, and a read at offset 0x10 with `master_idle` low returns 0x20000000.
- R2: The register answers only at offset 0x10. Its read value is: bit 31 = current `master_idle`; bits 30:11 = the constant pattern of the reset value (bit 29 one, the rest zero); bits 10:6 = select code; bit 5 = request bit; bits 4:0 = zero. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R3: A write at offset 0x10 with bit 5 set, made while no flush is pending, captures bits 10:6 as the select code and moves to ST_WAIT. The request bit reads 1 from the next cycle on.
- R4: While `xfer_active` is high or `master_idle` is low, a pending flush stays in ST_WAIT. The request bit stays 1 and `fifo_clr` stays zero.
- R5: For a select code from 0 to 15, `fifo_clr` carries only the bit whose index equals the code. It is high for exactly one cycle: the cycle after the first ST_WAIT cycle in which `master_idle` is high and `xfer_active` is low.
- R6: Select code 10000 drives every `fifo_clr` bit high for that one cycle.
- R7: Select codes 10001 to 11111 drive no `fifo_clr` bit. The request bit still clears on the same schedule.
- R8: The request bit still reads 1 in the clear cycle and reads 0 from the cycle after it.
- R9: While a flush is pending (ST_WAIT or ST_CLEAR), writes to the register are ignored entirely. The select code and request bit keep their values.
- R10: A write at offset 0x10 with bit 5 clear, made while idle, updates the select code only. No flush starts.
- R11: In host mode, code 00000 (non-periodic FIFO) pulses `fifo_clr[0]` and code 00001 (periodic FIFO) pulses `fifo_clr[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| master_idle | input | 1 | Bus master state machine is idle |
| xfer_active | input | 1 | A transaction is using the FIFOs |
| fifo_clr | output | 16 | One-cycle pointer clear, one line per FIFO |

## Verification
The assertions assume that `master_idle` and `xfer_active` are ordinary synchronous levels, sampled at the same edge as the machine. They also assume that software uses only the register write port to start flushes, so a clear pulse can only follow a quiet cycle seen in ST_WAIT. The stimulus changes every input one time unit after a rising edge and holds it across the next edge. It toggles the two quiet-path inputs so that flushes are held back, and it issues writes during pending flushes to test that such writes are ignored. Select codes cover single FIFOs, the all-FIFOs code and the unused codes.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int SEL_W     = 5;
    localparam int SEL_LSB   = 6;
    localparam int REQ_BIT   = 5;
    localparam int IDLE_BIT  = 31;
    localparam int DATA_W    = 32;
    localparam int MAX_FIFO  = 16;
    localparam logic [SEL_W-1:0] SEL_ALL = 5'b10000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CLEAR = 2'd2
    } flush_st_t;
endpackage

// File: rtl/txf_flush_fsm.sv
module txf_flush_fsm
    import txf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_req,
    input  logic             path_quiet,
    output logic             busy,
    output logic             clr_fire,
    output logic [SEL_W-1:0] sel_q
);
    flush_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_hit && wr_req) state_d = ST_WAIT;
            ST_WAIT:  if (path_quiet)       state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (state_q == ST_IDLE && wr_hit) begin
            sel_q <= wr_sel;
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        clr_fire = (state_q == ST_CLEAR);
    end
endmodule

// File: rtl/txf_sel_decode.sv
module txf_sel_decode
    import txf_pkg::*;
#(
    parameter int NUM_FIFO = 16
) (
    input  logic                fire,
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_FIFO-1:0] clr
);
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_FIFO - 1);

    logic hit_all;
    assign hit_all = (sel == SEL_ALL);

    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_line
        localparam logic [SEL_W-1:0] CODE = SEL_W'(i);
        assign clr[i] = fire && (hit_all || (sel == CODE && sel <= LAST_CODE));
    end
endmodule

// File: rtl/txf_reg_view.sv
module txf_reg_view
    import txf_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
    parameter logic [DATA_W-1:0] RESET_VAL  = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              master_idle,
    input  logic [SEL_W-1:0]  sel,
    input  logic              busy,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    localparam int RSV_LSB = SEL_LSB + SEL_W;

    assign hit = (addr == REG_OFFSET);

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[IDLE_BIT]                = master_idle;
            rdata[IDLE_BIT-1:RSV_LSB]      = RESET_VAL[IDLE_BIT-1:RSV_LSB];
            rdata[RSV_LSB-1:SEL_LSB]       = sel;
            rdata[REQ_BIT]                 = busy;
            rdata[REQ_BIT-1:0]             = RESET_VAL[REQ_BIT-1:0];
        end
    end
endmodule

// File: rtl/txf_flush_ctrl.sv
module txf_flush_ctrl
    import txf_pkg::*;
#(
    parameter int                NUM_FIFO   = 16,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
    parameter logic [31:0]       RESET_VAL  = 32'h2000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                master_idle,
    input  logic                xfer_active,
    output logic [NUM_FIFO-1:0] fifo_clr
);
    logic             reg_hit;
    logic             busy;
    logic             clr_fire;
    logic [SEL_W-1:0] sel_q;
    logic             path_quiet;
    logic             unused_wbits;

    assign path_quiet   = master_idle && !xfer_active;
    assign unused_wbits = ^{wdata[31:SEL_LSB+SEL_W], wdata[REQ_BIT-1:0]};

    txf_reg_view #(
        .ADDR_W    (ADDR_W),
        .REG_OFFSET(REG_OFFSET),
        .RESET_VAL (RESET_VAL)
    ) u_view (
        .addr       (addr),
        .master_idle(master_idle),
        .sel        (sel_q),
        .busy       (busy),
        .hit        (reg_hit),
        .rdata      (rdata)
    );

    txf_flush_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_en && reg_hit),
        .wr_sel    (wdata[SEL_LSB+SEL_W-1:SEL_LSB]),
        .wr_req    (wdata[REQ_BIT]),
        .path_quiet(path_quiet),
        .busy      (busy),
        .clr_fire  (clr_fire),
        .sel_q     (sel_q)
    );

    txf_sel_decode #(
        .NUM_FIFO(NUM_FIFO)
    ) u_dec (
        .fire(clr_fire),
        .sel (sel_q),
        .clr (fifo_clr)
    );
endmodule

// File: rtl/txf_flush_checker.sv
module txf_flush_checker
    import txf_pkg::*;
#(
    parameter int NUM_FIFO = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                master_idle,
    input logic                xfer_active,
    input logic                busy,
    input logic [SEL_W-1:0]    sel_q,
    input logic [NUM_FIFO-1:0] fifo_clr
);
    // R4: a clear pulse only follows a quiet cycle
    p_clr_after_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_clr) |-> $past(master_idle && !xfer_active));

    // R5: single codes clear at most one FIFO
    p_single_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != SEL_ALL) |-> $onehot0(fifo_clr));

    // R6: the all-FIFOs code clears every line
    p_all_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fifo_clr) && sel_q == SEL_ALL) |-> (&fifo_clr));

    // R8: request bit drops right after the pulse
    p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_clr) |=> !busy);

    // R8: no pulse without a pending request
    p_no_idle_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fifo_clr == '0));

    // R9: select code frozen while a flush is pending
    p_sel_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(sel_q));

    // R5: pulse lasts one cycle
    p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_clr) |=> (fifo_clr == '0));
endmodule

bind txf_flush_ctrl txf_flush_checker #(.NUM_FIFO(NUM_FIFO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_idle(master_idle),
    .xfer_active(xfer_active),
    .busy       (busy),
    .sel_q      (sel_q),
    .fifo_clr   (fifo_clr)
);

// File: tb/txf_flush_ctrl_test.sv
`timescale 1ns/1ps
module txf_flush_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        master_idle = 1'b0;
    logic        xfer_active = 1'b0;
    logic [15:0] fifo_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_st  = 0;   // 0 idle, 1 waiting, 2 clearing
    int m_sel = 0;

    always #2.5 clk = ~clk;

    txf_flush_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .master_idle(master_idle), .xfer_active(xfer_active),
        .fifo_clr(fifo_clr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sel = 0;
        end else begin
            case (m_st)
                0: if (wr_en && addr == 8'h10) begin
                       m_sel = int'(wdata[10:6]);
                       if (wdata[5]) m_st = 1;
                   end
                1: if (master_idle && !xfer_active) m_st = 2;
                default: m_st = 0;
            endcase
        end
    end

    function automatic logic [15:0] exp_clr();
        if (m_st != 2) return 16'h0;
        if (m_sel == 16) return 16'hFFFF;
        if (m_sel < 16) return 16'(1 << m_sel);
        return 16'h0;
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [31:0] v;
        if (addr != 8'h10) return 32'h0;
        v = 32'h2000_0000;
        v[31] = master_idle;
        v[10:6] = 5'(m_sel);
        v[5] = (m_st != 0);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(fifo_clr == exp_clr(), "R5 model fifo_clr", 32'(fifo_clr), 32'(exp_clr()));
            check(rdata == exp_rd(), "R2 model rdata", rdata, exp_rd());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [4:0] sel, input bit req);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a;
        wdata = 32'hFFFF_F81F & 32'h8000_001F;
        wdata[10:6] = sel; wdata[5] = req;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 8'h10; wdata = '0;
    endtask

    // issue a flush with the path quiet, check pulse and self clear
    task automatic run_flush(input logic [4:0] code, input logic [15:0] want, input string req);
        reg_write(8'h10, code, 1'b1);
        @(negedge clk);
        check(rdata[5] == 1'b1 && fifo_clr == 0, "R3 request pending", rdata, 32'h20);
        @(negedge clk);
        check(fifo_clr == want, req, 32'(fifo_clr), 32'(want));
        check(rdata[5] == 1'b1, "R8 bit set in clear cycle", rdata, 32'h20);
        @(negedge clk);
        check(rdata[5] == 1'b0 && fifo_clr == 0, "R8 bit cleared", rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rdata == 32'h2000_0000, "R1 reset read", rdata, 32'h2000_0000);
        check(fifo_clr == 0, "R1 reset clear lines", 32'(fifo_clr), 32'h0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(rdata == 32'h2000_0000, "R1 after reset", rdata, 32'h2000_0000);

        step(); master_idle = 1'b1;
        @(negedge clk);
        check(rdata == 32'hA000_0000, "R2 idle bit", rdata, 32'hA000_0000);

        // R10: select only
        reg_write(8'h10, 5'd3, 1'b0);
        @(negedge clk);
        check(rdata == 32'hA000_00C0, "R10 select only", rdata, 32'hA000_00C0);
        repeat (3) @(negedge clk);
        check(fifo_clr == 0 && rdata[5] == 0, "R10 no flush", rdata, 32'hA000_00C0);

        // R2: other offset
        reg_write(8'h14, 5'd7, 1'b1);
        addr = 8'h14;
        @(negedge clk);
        check(rdata == 0, "R2 other offset reads zero", rdata, 32'h0);
        step(); addr = 8'h10;
        @(negedge clk);
        check(rdata == 32'hA000_00C0, "R2 other offset write ignored", rdata, 32'hA000_00C0);

        // R4 and R9: held by active transfer, writes ignored
        step(); xfer_active = 1'b1;
        reg_write(8'h10, 5'd5, 1'b1);
        repeat (4) @(negedge clk);
        check(fifo_clr == 0 && rdata[5], "R4 held by transfer", rdata, 32'hA000_0160);
        reg_write(8'h10, 5'd9, 1'b0);
        @(negedge clk);
        check(rdata[10:6] == 5'd5 && rdata[5], "R9 write ignored", rdata, 32'hA000_0160);
        step(); xfer_active = 1'b0; master_idle = 1'b0;
        repeat (3) @(negedge clk);
        check(fifo_clr == 0 && rdata[5], "R4 held by busy master", 32'(fifo_clr), 32'h0);
        step(); master_idle = 1'b1;
        @(negedge clk);
        check(fifo_clr == 0, "R5 not before quiet cycle seen", 32'(fifo_clr), 32'h0);
        @(negedge clk);
        check(fifo_clr == 16'h0020, "R5 single FIFO 5", 32'(fifo_clr), 32'h20);
        @(negedge clk);
        check(rdata[5] == 0, "R8 cleared after held flush", rdata, 32'hA000_0140);

        run_flush(5'd15, 16'h8000, "R5 single FIFO 15");
        run_flush(5'd16, 16'hFFFF, "R6 all FIFOs");
        run_flush(5'd17, 16'h0000, "R7 unused code 17");
        run_flush(5'd31, 16'h0000, "R7 unused code 31");
        run_flush(5'd0,  16'h0001, "R11 non-periodic code 0");
        run_flush(5'd1,  16'h0002, "R11 periodic code 1");

        repeat (3) step();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule